// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block drives an active-low processor reset line in open-drain fashion: its output `rst_pull_en` turns on the pull-down, and the level of the shared line comes back in on `rst_line_in`. Three sources can start a reset. The first is a synchronous power-fail flag from an external comparator. The second is a pushbutton, or any other agent, that pulls the shared line low. The third is a watchdog that the processor restarts with falling edges on a strobe input. A one-cycle timebase enable, `tick_ms`, gives the block its millisecond resolution. All durations are counted in these ticks.

A generated reset pulse always lasts a fixed number of ticks. The block ignores its own pull-down when it looks for a pushbutton press. When a pulse ends, the block briefly releases the line and checks it. If the line is still held low from outside, the block waits for release and then issues a fresh pulse. A 2-bit watchdog delay register, written through a one-cycle write strobe, selects whether the watchdog is off or which of three timeouts it uses.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_fail` is 1, `rst_pull_en` is 1 from the first clock edge after `pwr_fail` rises.
- R2: After `pwr_fail` falls, `rst_pull_en` stays 1 for exactly PULSE_MS further ticks and then drops to 0.
- R3: After `arst_n` is released, `rst_pull_en` is 1 and `cfg_delay` reads 2'b11. The power-up pulse lasts exactly PULSE_MS ticks.
- R4: A press is recognised only when the synchronised line has been low, with the block not driving it, for DEBOUNCE_MS consecutive ticks. A press starts a reset pulse. A low lasting 2 ticks or less starts nothing.
- R5: A pulse started by a press lasts exactly PULSE_MS ticks.
- R6: If the line is still held low when a pulse ends, `rst_pull_en` stays 0 for as long as the line stays low. Once the line is released, a new pulse of PULSE_MS ticks follows.
- R7: The block's own pull-down never counts as a press. After a pulse ends with the line released, no further pulse starts.
- R8: The delay code in `cfg_delay` selects the watchdog timeout: 2'b00 turns the watchdog off, 2'b01 gives WD_BASE_MS ticks, 2'b10 gives 2*WD_BASE_MS and 2'b11 gives 4*WD_BASE_MS. Counting starts when the pull-down is released. Without a strobe, a timeout happens after exactly that many ticks.
- R9: A falling edge on `strobe_n`, passed through a two-flop synchroniser, restarts the watchdog count. Falling edges that are closer together than the timeout prevent any reset.
- R10: A cycle with `cfg_wr` = 1 loads `cfg_wdata` into `cfg_delay` and restarts the watchdog count.
- R11: A watchdog timeout starts a reset pulse of exactly PULSE_MS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_ms | input | 1 | One-cycle enable, once per millisecond |
| pwr_fail | input | 1 | Power-fail flag from external comparator, synchronous to clk |
| rst_line_in | input | 1 | Level of the shared reset line |
| strobe_n | input | 1 | Watchdog strobe; falling edges restart the timer |
| cfg_wr | input | 1 | Write strobe for the delay register |
| cfg_wdata | input | 2 | New watchdog delay code |
| cfg_delay | output | 2 | Current watchdog delay code |
| rst_pull_en | output | 1 | 1 = pull the shared reset line low |

## Verification
The assertions rely on three things about the inputs: `pwr_fail` is already synchronous to `clk`, `tick_ms` is a single-cycle pulse, and the shared line reads low whenever the block pulls it down. The bench meets all three. It models the line as the wired AND of the block's pull-down and a pushbutton, and it drives every input half a cycle away from the active edge. It keeps `tick_ms` high for one cycle in every four. It holds strobe lows for two cycles so the synchroniser always catches them. It draws strobe gaps at random, but always at least two ticks shorter than the selected timeout.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_IDLE   = 2'd2,
    ST_HELD   = 2'd3
  } rsv_state_e;

  // Timeout in ticks for a delay code; zero means disabled.
  function automatic int unsigned wd_limit_ms(input logic [1:0] code,
                                              input int unsigned base);
    case (code)
      2'b01:   return base;
      2'b10:   return base * 2;
      2'b11:   return base * 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) chain_q[i] <= RST_VAL;
          else         chain_q[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) chain_q[i] <= RST_VAL;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rsv_debounce.sv
module rsv_debounce #(
  parameter int unsigned DEB_MS = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en,
  input  logic tick,
  input  logic line_low,
  output logic press
);
  localparam int unsigned CW = $clog2(DEB_MS + 1);

  logic [CW-1:0] cnt_q;
  logic          armed;

  assign armed = en & line_low;
  assign press = armed & tick & (cnt_q == CW'(DEB_MS - 1));

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)              cnt_q <= '0;
    else if (!armed || press) cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_q + CW'(1);

  AST_DEB_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q < CW'(DEB_MS)); // R4
endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog
  import rsv_pkg::*;
#(
  parameter int unsigned BASE_MS = 250
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       strobe_fall,
  input  logic       cfg_wr,
  input  logic [1:0] code,
  output logic       timeout
);
  localparam int unsigned CW = $clog2(4 * BASE_MS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          restart;

  assign limit   = CW'(wd_limit_ms(code, BASE_MS));
  assign restart = !run || strobe_fall || cfg_wr || (code == 2'b00);
  assign timeout = !restart && tick && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                 cnt_q <= '0;
    else if (restart || timeout) cnt_q <= '0;
    else if (tick)               cnt_q <= cnt_q + CW'(1);

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    (run && code != 2'b00) |-> (cnt_q < limit)); // R8
endmodule

// File: rtl/rsv_pulse_fsm.sv
module rsv_pulse_fsm
  import rsv_pkg::*;
#(
  parameter int unsigned PULSE_MS   = 250,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic pwr_fail,
  input  logic press,
  input  logic wd_timeout,
  input  logic line_low,
  output logic pull_en,
  output logic wd_run,
  output logic deb_en
);
  localparam int unsigned HW = $clog2(PULSE_MS + 1);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);

  rsv_state_e    state_q, state_d;
  logic [HW-1:0] hold_q, hold_d;
  logic [SW-1:0] settle_q, settle_d;
  logic          pulse_done;

  assign pulse_done = (state_q == ST_HOLD) && tick && (hold_q == HW'(PULSE_MS - 1));

  always_comb begin
    state_d  = state_q;
    hold_d   = hold_q;
    settle_d = settle_q;
    if (pwr_fail) begin
      state_d = ST_HOLD;
      hold_d  = '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (pulse_done) begin
            state_d  = ST_SETTLE;
            hold_d   = '0;
            settle_d = '0;
          end else if (tick) begin
            hold_d = hold_q + HW'(1);
          end
        end
        ST_SETTLE: begin
          if (wd_timeout)                        state_d = ST_HOLD;
          else if (settle_q == SW'(SETTLE_CYC))  state_d = line_low ? ST_HELD : ST_IDLE;
          else                                   settle_d = settle_q + SW'(1);
        end
        ST_IDLE: begin
          if (press || wd_timeout) state_d = ST_HOLD;
        end
        ST_HELD: begin
          if (!line_low) state_d = ST_HOLD;
        end
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      state_q  <= ST_HOLD;
      hold_q   <= '0;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      hold_q   <= hold_d;
      settle_q <= settle_d;
    end

  assign pull_en = (state_q == ST_HOLD);
  assign wd_run  = (state_q == ST_IDLE) || (state_q == ST_SETTLE);
  assign deb_en  = (state_q == ST_IDLE);

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    hold_q < HW'(PULSE_MS)); // R5
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_HELD && line_low && !pwr_fail) |=> !pull_en); // R6
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned PULSE_MS    = 250,
  parameter int unsigned DEBOUNCE_MS = 10,
  parameter int unsigned WD_BASE_MS  = 250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick_ms,
  input  logic       pwr_fail,
  input  logic       rst_line_in,
  input  logic       strobe_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdata,
  output logic [1:0] cfg_delay,
  output logic       rst_pull_en
);
  logic line_s, line_low;
  logic strobe_s, strobe_prev_q, strobe_fall;
  logic press, wd_timeout, wd_run, deb_en;
  logic [1:0] delay_q;

  rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_line_sync (
    .clk(clk), .arst_n(arst_n), .d(rst_line_in), .q(line_s));
  rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strobe_sync (
    .clk(clk), .arst_n(arst_n), .d(strobe_n), .q(strobe_s));

  assign line_low = ~line_s;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) strobe_prev_q <= 1'b1;
    else         strobe_prev_q <= strobe_s;

  assign strobe_fall = strobe_prev_q & ~strobe_s;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)     delay_q <= 2'b11;
    else if (cfg_wr) delay_q <= cfg_wdata;

  assign cfg_delay = delay_q;

  rsv_debounce #(.DEB_MS(DEBOUNCE_MS)) u_deb (
    .clk(clk), .arst_n(arst_n), .en(deb_en), .tick(tick_ms),
    .line_low(line_low), .press(press));

  rsv_watchdog #(.BASE_MS(WD_BASE_MS)) u_wd (
    .clk(clk), .arst_n(arst_n), .tick(tick_ms), .run(wd_run),
    .strobe_fall(strobe_fall), .cfg_wr(cfg_wr), .code(delay_q),
    .timeout(wd_timeout));

  rsv_pulse_fsm #(.PULSE_MS(PULSE_MS), .SETTLE_CYC(SYNC_STAGES)) u_fsm (
    .clk(clk), .arst_n(arst_n), .tick(tick_ms), .pwr_fail(pwr_fail),
    .press(press), .wd_timeout(wd_timeout), .line_low(line_low),
    .pull_en(rst_pull_en), .wd_run(wd_run), .deb_en(deb_en));

  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    pwr_fail |=> rst_pull_en); // R1
  AST_PRESS_FIRES: assert property (@(posedge clk) disable iff (!arst_n)
    press |=> rst_pull_en); // R4
  AST_NO_SELF_PRESS: assert property (@(posedge clk) disable iff (!arst_n)
    rst_pull_en |-> !press); // R7
  AST_WD_FIRES: assert property (@(posedge clk) disable iff (!arst_n)
    wd_timeout |=> rst_pull_en); // R11
  AST_WD_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
    rst_pull_en |-> !wd_timeout); // R8
  AST_WD_OFF: assert property (@(posedge clk) disable iff (!arst_n)
    (delay_q == 2'b00) |-> !wd_timeout); // R8
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int P   = 6;
  localparam int DEB = 4;
  localparam int WB  = 5;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic pwr_fail = 1'b0;
  logic btn_low = 1'b0;
  logic strobe_n = 1'b1;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic [1:0] cfg_delay;
  logic rst_pull_en;
  logic rst_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign rst_line = ~(btn_low | rst_pull_en);

  rst_supervisor #(.PULSE_MS(P), .DEBOUNCE_MS(DEB), .WD_BASE_MS(WB), .SYNC_STAGES(2))
    u_rst_supervisor (
      .clk(clk), .arst_n(arst_n), .tick_ms(tick_ms), .pwr_fail(pwr_fail),
      .rst_line_in(rst_line), .strobe_n(strobe_n), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_delay(cfg_delay), .rst_pull_en(rst_pull_en));

  always #4 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(posedge clk);
      #1;
      tick_ms = (div == 3);
      div = (div + 1) % 4;
    end
  end

  function automatic int exp_timeout(input logic [1:0] code);
    if (code == 2'b00) return 0;
    return WB << (code - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drv_point();
    @(negedge clk);
    #1;
  endtask

  // Called at negedge+2: counts ticks bound for the next edge until the pull-down equals lvl.
  task automatic run_until(input logic lvl, input int max_cyc, output int ticks, output bit hit);
    ticks = 0;
    hit = 0;
    for (int c = 0; c < max_cyc; c++) begin
      if (rst_pull_en == lvl) begin
        hit = 1;
        break;
      end
      if (tick_ms) ticks++;
      @(negedge clk);
      #2;
    end
  endtask

  task automatic set_code(input logic [1:0] code);
    int t; bit h;
    drv_point(); pwr_fail = 1'b1; #1;
    drv_point(); #1;
    chk(rst_pull_en == 1'b1, "R1 pull while power fail", rst_pull_en, 1);
    drv_point(); cfg_wr = 1'b1; cfg_wdata = code; #1;
    chk(rst_pull_en == 1'b1, "R1 pull while power fail", rst_pull_en, 1);
    drv_point(); cfg_wr = 1'b0; #1;
    drv_point(); pwr_fail = 1'b0; #1;
    chk(cfg_delay == code, "R10 delay readback", cfg_delay, code);
    run_until(1'b0, 400, t, h);
    chk(h && t == P, "R2 pulse after power fail", t, P);
  endtask

  initial begin
    int t; bit h; int lim;
    void'($urandom(32'h1357));
    repeat (3) @(posedge clk);
    #1 arst_n = 1'b1;
    @(negedge clk); #2;

    chk(rst_pull_en == 1'b1, "R3 pull after reset", rst_pull_en, 1);
    chk(cfg_delay == 2'b11, "R3 delay code after reset", cfg_delay, 3);
    run_until(1'b0, 400, t, h);
    chk(h && t == P, "R3 power-up pulse", t, P);

    run_until(1'b1, 400, t, h);
    chk(h && t == exp_timeout(2'b11), "R8 default timeout", t, exp_timeout(2'b11));
    run_until(1'b0, 400, t, h);
    chk(h && t == P, "R11 watchdog pulse", t, P);

    for (int code = 1; code <= 2; code++) begin
      set_code(code[1:0]);
      run_until(1'b1, 400, t, h);
      chk(h && t == exp_timeout(code[1:0]), "R8 timeout for code", t, exp_timeout(code[1:0]));
      run_until(1'b0, 400, t, h);
      chk(h && t == P, "R11 watchdog pulse", t, P);
    end

    // R10: a write in idle restarts the count
    set_code(2'b01);
    run_until(1'b1, 12, t, h);
    chk(!h, "R10 no early timeout", h, 0);
    drv_point(); cfg_wr = 1'b1; cfg_wdata = 2'b01; #1;
    drv_point(); cfg_wr = 1'b0; #1;
    run_until(1'b1, 400, t, h);
    chk(h && t == WB, "R10 write restarts count", t, WB);
    run_until(1'b0, 400, t, h);
    chk(h && t == P, "R11 watchdog pulse", t, P);

    // R8: disabled watchdog
    set_code(2'b00);
    run_until(1'b1, 600, t, h);
    chk(!h, "R8 disabled never fires", h, 0);

    // R4: short press ignored
    drv_point(); btn_low = 1'b1; #1;
    repeat (8) begin drv_point(); #1; end
    drv_point(); btn_low = 1'b0; #1;
    run_until(1'b1, 100, t, h);
    chk(!h, "R4 short press ignored", h, 0);

    // R4/R5/R6: long press held past the pulse
    drv_point(); btn_low = 1'b1; #1;
    run_until(1'b1, 200, t, h);
    chk(h && t >= DEB && t <= DEB + 1, "R4 debounce length", t, DEB);
    run_until(1'b0, 400, t, h);
    chk(h && t == P, "R5 press pulse length", t, P);
    run_until(1'b1, 60, t, h);
    chk(!h, "R6 no pulse while held", h, 0);
    drv_point(); btn_low = 1'b0; #1;
    run_until(1'b1, 20, t, h);
    chk(h, "R6 pulse on release", h, 1);
    run_until(1'b0, 400, t, h);
    chk(h && t == P, "R6 release pulse length", t, P);
    run_until(1'b1, 120, t, h);
    chk(!h, "R7 no retrigger after self pulse", h, 0);

    // R7: press released during the pulse
    drv_point(); btn_low = 1'b1; #1;
    run_until(1'b1, 200, t, h);
    repeat (8) begin drv_point(); #1; end
    drv_point(); btn_low = 1'b0; #1;
    run_until(1'b0, 400, t, h);
    chk(h, "R5 pulse ends", h, 1);
    run_until(1'b1, 120, t, h);
    chk(!h, "R7 no retrigger after release", h, 0);

    // R9: random strobe gaps below the timeout, then silence
    for (int it = 0; it < 6; it++) begin
      logic [1:0] code;
      code = 2'(1 + ($urandom % 3));
      lim = exp_timeout(code);
      set_code(code);
      for (int k = 0; k < 4; k++) begin
        int g;
        g = 1 + int'($urandom % (lim - 2));
        run_until(1'b1, 4 * g, t, h);
        chk(!h, "R9 strobe keeps reset off", h, 0);
        drv_point(); strobe_n = 1'b0; #1;
        drv_point(); #1;
        drv_point(); strobe_n = 1'b1; #1;
      end
      run_until(1'b1, 4 * (lim + 4), t, h);
      chk(h && t >= lim && t <= lim + 1, "R9 timeout after last strobe", t, lim);
      run_until(1'b0, 400, t, h);
      chk(h && t == P, "R11 watchdog pulse", t, P);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule